// File: doc/BRIEF.md
# Temperature Scratchpad with Alarm Flag

This block is the register layer behind a digital thermometer. It holds the latest temperature result, a high and a low alarm threshold byte, and a resolution setting. Each raw 12-bit signed measurement arrives with a one-cycle strobe. The block keeps only as many fraction bits as the selected resolution allows and stores the result as a 16-bit sign-extended word. The threshold bytes and the setting are loaded through write strobes that share one data byte.

A combinational byte-addressed read port gives serial or bus logic access to the five stored bytes. An alarm flag is worked out at each measurement by comparing the integer degrees against the two thresholds. The flag keeps its value until the next measurement.

Top module: `temp_scratchpad`

## Requirements
- R1: After reset, temp_word is 0x0000, the high threshold reads 0x7F, the low threshold reads 0x80, the setting byte reads 0x7F (12-bit mode) and alarm is 0.
- R2: When meas_valid is high at a clock edge, temp_word from that edge on equals meas_raw sign-extended to 16 bits, with its insignificant low bits zeroed. Without meas_valid, temp_word holds its value.
- R3: The resolution field is setting bits 6:5. The value 00 selects 9 bits and clears raw bits 2:0. The value 01 selects 10 bits and clears bits 1:0. The value 10 selects 11 bits and clears bit 0. The value 11 selects 12 bits and clears nothing. A measurement uses the resolution in effect before its edge, even when a setting write falls in the same cycle.
- R4: A write through cfg_we stores only wr_data bits 6:5. Setting bits 4:0 always read as 1 and bit 7 always reads as 0.
- R5: hi_we stores wr_data as the high threshold and lo_we stores wr_data as the low threshold. Each is a signed byte.
- R6: The read port returns rd_data as follows: address 0 gives temp_word[7:0], address 1 gives temp_word[15:8], address 2 gives the high threshold, address 3 gives the low threshold, address 4 gives the setting byte, and addresses 5 to 7 give 0x00.
- R7: At each measurement, alarm becomes 1 when the signed integer part meas_raw[11:4] is greater than the high threshold or less than the low threshold. Otherwise it becomes 0. Equality does not raise the alarm.
- R8: alarm changes only at a measurement. Threshold writes on their own leave it unchanged. A measurement in the same cycle as a threshold write compares against the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | Strobe: meas_raw holds a new measurement |
| meas_raw | input | 12 | Signed measurement, 4 fraction bits |
| hi_we | input | 1 | Write strobe for the high threshold |
| lo_we | input | 1 | Write strobe for the low threshold |
| cfg_we | input | 1 | Write strobe for the setting byte |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read byte, combinational |
| temp_word | output | 16 | Stored sign-extended temperature |
| alarm | output | 1 | Alarm flag from the last measurement |

## Verification
Every stored byte reaches the read port without delay. A corrupted threshold or setting therefore shows at rd_data in the same cycle it is addressed, and a wrong mask shows at temp_word one edge after the measurement strobe. A wrong comparison appears on alarm one edge after the strobe. A flag that moves on a threshold write is visible at the very next edge, before any later measurement could hide it. The directed scenarios cover signed boundaries, equality and same-cycle collisions, so sign, order and priority faults surface within a few cycles of the stimulus.

// File: rtl/temp_scratchpad.sv
module temp_scratchpad #(
  parameter logic [7:0] HI_RESET = 8'h7F,
  parameter logic [7:0] LO_RESET = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        meas_valid,
  input  logic [11:0] meas_raw,
  input  logic        hi_we,
  input  logic        lo_we,
  input  logic        cfg_we,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic [15:0] temp_word,
  output logic        alarm
);
  logic [1:0]  res_q;
  logic [7:0]  hi_q, lo_q;
  logic [15:0] temp_q;
  logic        alarm_q;
  logic [11:0] keep_mask;
  logic [11:0] masked;
  logic        over, under;

  always_comb begin
    case (res_q)
      2'b00:   keep_mask = 12'hFF8;
      2'b01:   keep_mask = 12'hFFC;
      2'b10:   keep_mask = 12'hFFE;
      default: keep_mask = 12'hFFF;
    endcase
  end

  assign masked = meas_raw & keep_mask;
  assign over   = $signed(meas_raw[11:4]) > $signed(hi_q);
  assign under  = $signed(meas_raw[11:4]) < $signed(lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= 2'b11;
      hi_q    <= HI_RESET;
      lo_q    <= LO_RESET;
      temp_q  <= 16'h0000;
      alarm_q <= 1'b0;
    end else begin
      if (cfg_we) res_q <= wr_data[6:5];
      if (hi_we)  hi_q  <= wr_data;
      if (lo_we)  lo_q  <= wr_data;
      if (meas_valid) begin
        temp_q  <= {{4{masked[11]}}, masked};
        alarm_q <= over | under;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = temp_q[7:0];
      3'd1:    rd_data = temp_q[15:8];
      3'd2:    rd_data = hi_q;
      3'd3:    rd_data = lo_q;
      3'd4:    rd_data = {1'b0, res_q, 5'h1F};
      default: rd_data = 8'h00;
    endcase
  end

  assign temp_word = temp_q;
  assign alarm     = alarm_q;
endmodule

module temp_scratchpad_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        meas_valid,
  input logic [2:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic [15:0] temp_word,
  input logic        alarm,
  input logic [1:0]  res
);
  AST_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 3'd4 |-> (rd_data[4:0] == 5'h1F && !rd_data[7])); // R4
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_word[15:11] == 5'h00 || temp_word[15:11] == 5'h1F)); // R2
  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(temp_word)); // R2
  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(alarm)); // R8
  AST_MASK_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && res == 2'b00) |=> temp_word[2:0] == 3'b000); // R3
  AST_READ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 3'd0 |-> rd_data == temp_word[7:0]); // R6
endmodule

bind temp_scratchpad temp_scratchpad_chk u_chk (
  .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .rd_addr(rd_addr),
  .rd_data(rd_data), .temp_word(temp_word), .alarm(alarm), .res(res_q)
);

// File: tb/tb_temp_scratchpad.sv
module tb_temp_scratchpad;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_valid = 1'b0;
  logic [11:0] meas_raw = '0;
  logic hi_we = 1'b0, lo_we = 1'b0, cfg_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [15:0] temp_word;
  logic alarm;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  temp_scratchpad dut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_raw(meas_raw),
    .hi_we(hi_we), .lo_we(lo_we), .cfg_we(cfg_we), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .temp_word(temp_word), .alarm(alarm)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] model_temp(input logic [11:0] raw, input int bits);
    logic [11:0] r;
    r = (raw >> (12 - bits)) << (12 - bits);
    return {{4{r[11]}}, r};
  endfunction

  function automatic logic model_alarm(input logic [11:0] raw, input logic [7:0] hi, input logic [7:0] lo);
    int v, h, l;
    v = $signed(raw[11:4]);
    h = $signed(hi);
    l = $signed(lo);
    return (v > h) || (v < l);
  endfunction

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    hi_we = (which == 0);
    lo_we = (which == 1);
    cfg_we = (which == 2);
    @(negedge clk);
    hi_we = 0; lo_we = 0; cfg_we = 0;
  endtask

  task automatic measure(input logic [11:0] raw);
    @(negedge clk);
    meas_raw = raw;
    meas_valid = 1;
    @(negedge clk);
    meas_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 temp", temp_word, 16'h0000);
    chk("R1 alarm", {15'd0, alarm}, 16'd0);
    rd(3'd2, d); chk("R1 hi", {8'd0, d}, 16'h7F);
    rd(3'd3, d); chk("R1 lo", {8'd0, d}, 16'h80);
    rd(3'd4, d); chk("R1 cfg", {8'd0, d}, 16'h7F);
    rd(3'd5, d); chk("R6 addr5", {8'd0, d}, 16'h00);
    rd(3'd7, d); chk("R6 addr7", {8'd0, d}, 16'h00);
  endtask

  task automatic t_full_res;
    logic [7:0] lo_b, hi_b;
    measure(12'h191);
    chk("R2 pos12", temp_word, model_temp(12'h191, 12));
    rd(3'd0, lo_b); rd(3'd1, hi_b);
    chk("R6 bytes", {hi_b, lo_b}, 16'h0191);
    measure(12'hF5E);
    chk("R2 neg12", temp_word, 16'hFF5E);
    @(negedge clk); @(negedge clk);
    chk("R2 hold", temp_word, 16'hFF5E);
  endtask

  task automatic t_resolution;
    logic [7:0] d;
    wr(2, 8'h00);
    rd(3'd4, d); chk("R4 cfg00", {8'd0, d}, 16'h1F);
    measure(12'h7FF); chk("R3 nine", temp_word, 16'h07F8);
    measure(12'hF5F); chk("R3 nine neg", temp_word, model_temp(12'hF5F, 9));
    wr(2, 8'h20);
    rd(3'd4, d); chk("R4 cfg01", {8'd0, d}, 16'h3F);
    measure(12'h7FF); chk("R3 ten", temp_word, 16'h07FC);
    wr(2, 8'h40);
    measure(12'h7FF); chk("R3 eleven", temp_word, 16'h07FE);
    wr(2, 8'hFF);
    rd(3'd4, d); chk("R4 bit7 ignored", {8'd0, d}, 16'h7F);
    measure(12'h7FF); chk("R3 twelve", temp_word, 16'h07FF);
    wr(2, 8'h80);
    rd(3'd4, d); chk("R4 write 80", {8'd0, d}, 16'h1F);
    @(negedge clk);
    meas_raw = 12'h7FF; meas_valid = 1; wr_data = 8'h60; cfg_we = 1;
    @(negedge clk);
    meas_valid = 0; cfg_we = 0;
    chk("R3 same-cycle old res", temp_word, 16'h07F8);
    rd(3'd4, d); chk("R3 new res stored", {8'd0, d}, 16'h7F);
  endtask

  task automatic t_alarm;
    logic [7:0] d;
    wr(0, 8'h19); wr(1, 8'h0A);
    rd(3'd2, d); chk("R5 hi", {8'd0, d}, 16'h19);
    rd(3'd3, d); chk("R5 lo", {8'd0, d}, 16'h0A);
    measure(12'h1A0);
    chk("R7 above", {15'd0, alarm}, {15'd0, model_alarm(12'h1A0, 8'h19, 8'h0A)});
    wr(0, 8'h7F);
    chk("R8 hi write keeps", {15'd0, alarm}, 16'd1);
    measure(12'h140); chk("R7 inside", {15'd0, alarm}, 16'd0);
    wr(0, 8'h19);
    measure(12'h198); chk("R7 equal hi", {15'd0, alarm}, 16'd0);
    measure(12'h090); chk("R7 below", {15'd0, alarm}, 16'd1);
    wr(1, 8'h00);
    chk("R8 lo write keeps", {15'd0, alarm}, 16'd1);
    wr(1, 8'hF6);
    measure(12'hF50); chk("R7 signed below", {15'd0, alarm}, 16'd1);
    measure(12'hF60); chk("R7 signed equal lo", {15'd0, alarm}, 16'd0);
    @(negedge clk);
    meas_raw = 12'h1A0; meas_valid = 1; wr_data = 8'h7F; hi_we = 1;
    @(negedge clk);
    meas_valid = 0; hi_we = 0;
    chk("R8 same-cycle old hi", {15'd0, alarm}, 16'd1);
  endtask

  initial begin
    #10;
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_res();
    t_resolution();
    t_alarm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule